// File: doc/BRIEF.md
# Frame-Tick Interrupt Status Controller

This block gathers interrupt events into a 32-bit status register and gates them with a 32-bit enable register. It drives one level-sensitive request line, `irq`, which is high while any status bit is set whose enable bit is also set. Outside sources raise their status bits with one-cycle set pulses. One source is internal: a vertical-blank generator. It is a tick counter that, while it runs, sets status bit 0 once per frame period. The frame period is a parameter in clock cycles. Its default is one sixtieth of a second at 100 MHz, and a testbench can shorten it.

Software uses a single-cycle register port. With `reg_sel` = 0 the port selects the enable register and with `reg_sel` = 1 it selects the status register. Writing the enable register with bit 0 set does two things in the same cycle: it raises a vertical-blank event and it restarts the frame period. Writing the enable register with bit 0 clear stops the generator. Status bits are write-one-to-clear. The write data is first ANDed with a mask that depends on the variant, so only some bits can be cleared by software.

The generator is a two-state machine. In `TMR_IDLE` the counter is held at zero and no tick occurs. In `TMR_RUN` the counter advances every cycle and issues a tick on the last count of each period. The transitions are:
- `start`: IDLE→RUN, or RUN→RUN with the counter restarted, on an enable write with bit 0 set.
- `stop`: RUN→IDLE on an enable write with bit 0 clear.
- `wrap`: RUN→RUN with the counter back at zero after a tick.
- Reset sends the machine to IDLE.

Top module: `vbl_irq_ctrl`

## Requirements
- R1: `irq` equals the OR over all 32 bits of (status AND enable), in every cycle.
- R2: A write of the status register clears each status bit whose written bit is 1 and whose variant-mask bit is 1. The mask is 0x000F040F for variant A (`VARIANT_B`=0) and 0xFC080EFF for variant B (`VARIANT_B`=1). All other status bits keep their value.
- R3: An enable write with bit 0 set sets status bit 0 at that clock edge. The next generator tick then comes exactly `FRAME_CYCLES` cycles after the write, even if the generator was already running.
- R4: An enable write with bit 0 clear stops the generator. No vertical-blank event occurs until the next enable write with bit 0 set.
- R5: While the generator runs, status bit 0 is set once every `FRAME_CYCLES` cycles.
- R6: After reset, status and enable are zero, the generator is stopped and `irq` is low.
- R7: A 1 on bit n of `src_set` in one cycle sets status bit n at that clock edge.
- R8: When a set event (source pulse, tick or enable write) and a software clear hit the same bit in the same cycle, the bit ends up set.
- R9: An enable write stores all 32 bits of the write data, and those bits read back unchanged.
- R10: `reg_rdata` returns the enable register when `reg_sel` = 0 and the status register when `reg_sel` = 1, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | 0 selects enable, 1 selects status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| src_set | input | 32 | One-cycle set pulses, one per status bit |
| irq | output | 1 | Level interrupt request |

## Verification
The in-line assertions check on every cycle that a set wins over a same-cycle clear, that a masked clear takes effect, that a start write puts the counter back to zero in the running state, and that a stop write idles the generator. Other behaviour shows only in the bench scenarios, where a behavioural model is compared with both variants on every clock:
- the exact tick spacing over several frames,
- the restart of a period partway through,
- the silence after a stop,
- the bits the mask protects in each variant,
- the return to a quiet state after reset in the middle of a frame.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    localparam logic SEL_ENABLE = 1'b0;
    localparam logic SEL_STATUS = 1'b1;

    localparam logic [31:0] CLR_MASK_A = 32'h000F_040F;
    localparam logic [31:0] CLR_MASK_B = 32'hFC08_0EFF;

    function automatic logic [31:0] clr_mask(input bit variant_b);
        return variant_b ? CLR_MASK_B : CLR_MASK_A;
    endfunction
endpackage

// File: rtl/vbl_timer.sv
module vbl_timer
    import vbl_pkg::*;
#(
    parameter int FRAME_CYCLES = 1666667
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    output logic tick_o
);
    localparam int CNT_W = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_IDLE: begin
                cnt_d = '0;
                if (start_i) state_d = TMR_RUN;
            end
            TMR_RUN: begin
                if (start_i) begin
                    cnt_d = '0;
                end else if (stop_i) begin
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        tick_o = 1'b0;
        unique case (state_q)
            TMR_IDLE: tick_o = 1'b0;
            TMR_RUN:  tick_o = (cnt_q == LAST);
            default:  tick_o = 1'b0;
        endcase
    end

    // R3
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == TMR_RUN && cnt_q == '0));
    // R4
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (state_q == TMR_IDLE && !tick_o));
    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/irq_status.sv
module irq_status #(
    parameter int          W        = 32,
    parameter logic [31:0] CLR_MASK = 32'h000F_040F
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_wr_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] stat_o
);
    localparam logic [W-1:0] MASK = CLR_MASK[W-1:0];

    logic [W-1:0] stat_q;
    logic [W-1:0] clr_bits;

    assign clr_bits = clr_wr_i ? (clr_data_i & MASK) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_bits) | set_i;
    end

    assign stat_o = stat_q;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));
    // R2
    masked_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> ((stat_q & $past(clr_data_i & MASK & ~set_i)) == '0));
endmodule

// File: rtl/vbl_irq_ctrl.sv
module vbl_irq_ctrl
    import vbl_pkg::*;
#(
    parameter bit VARIANT_B    = 1'b0,
    parameter int FRAME_CYCLES = 1666667,
    parameter int VBL_BIT      = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] src_set,
    output logic        irq
);
    localparam int          W    = 32;
    localparam logic [31:0] MASK = clr_mask(VARIANT_B);

    logic         en_wr, st_wr, vbl_start, vbl_stop, tick;
    logic [W-1:0] en_q, stat, set_all, vbl_vec;

    assign en_wr     = reg_wr && (reg_sel == SEL_ENABLE);
    assign st_wr     = reg_wr && (reg_sel == SEL_STATUS);
    assign vbl_start = en_wr &&  reg_wdata[VBL_BIT];
    assign vbl_stop  = en_wr && !reg_wdata[VBL_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= reg_wdata;
    end

    vbl_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(vbl_start),
        .stop_i (vbl_stop),
        .tick_o (tick)
    );

    always_comb begin
        vbl_vec          = '0;
        vbl_vec[VBL_BIT] = tick | vbl_start;
    end
    assign set_all = src_set | vbl_vec;

    irq_status #(.W(W), .CLR_MASK(MASK)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_all),
        .clr_wr_i  (st_wr),
        .clr_data_i(reg_wdata),
        .stat_o    (stat)
    );

    assign irq       = |(stat & en_q);
    assign reg_rdata = (reg_sel == SEL_STATUS) ? stat : en_q;

    // R3
    start_sets_vbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vbl_start |=> stat[VBL_BIT]);
    // R9
    enable_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_q == $past(reg_wdata)));
endmodule

// File: tb/sim_vbl_irq_ctrl.sv
module sim_vbl_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] src_set = '0;
    logic [31:0] rd0, rd1;
    logic        irq0, irq1;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R6";
    bit    done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbl_irq_ctrl #(.VARIANT_B(1'b0), .FRAME_CYCLES(FRAME)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rd0), .src_set(src_set), .irq(irq0));
    vbl_irq_ctrl #(.VARIANT_B(1'b1), .FRAME_CYCLES(FRAME)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rd1), .src_set(src_set), .irq(irq1));

    // behavioural reference, one per variant
    logic [31:0] m_stat [2];
    logic [31:0] m_en   [2];
    bit          m_run  [2];
    int          m_age  [2];
    logic [31:0] m_mask [2] = '{32'h000F_040F, 32'hFC08_0EFF};

    task automatic compare(int v, logic [31:0] rd, logic irqv);
        logic [31:0] exp_rd;
        logic        exp_irq;
        exp_rd  = reg_sel ? m_stat[v] : m_en[v];
        exp_irq = |(m_stat[v] & m_en[v]);
        vectors += 2;
        if (irqv !== exp_irq) begin
            miscompares++;
            $display("FAIL %s/R1 u%0d irq act %b exp %b t=%0t", cur_req, v, irqv, exp_irq, $time);
        end
        if (rd !== exp_rd) begin
            miscompares++;
            $display("FAIL %s/R10 u%0d rdata act %h exp %h t=%0t", cur_req, v, rd, exp_rd, $time);
        end
    endtask

    always @(posedge clk) begin
        bit          w, s;
        logic [31:0] d, ss;
        w = reg_wr; s = reg_sel; d = reg_wdata; ss = src_set;
        for (int v = 0; v < 2; v++) begin
            if (!rst_n) begin
                m_stat[v] = '0; m_en[v] = '0; m_run[v] = 0; m_age[v] = 0;
            end else begin
                logic [31:0] setv, clrv;
                bit          tk;
                tk   = m_run[v] && (m_age[v] == FRAME - 1);
                setv = ss;
                if (tk) setv[0] = 1'b1;
                clrv = (w && s) ? (d & m_mask[v]) : 32'h0;
                if (w && !s) begin
                    m_en[v] = d;
                    if (d[0]) begin setv[0] = 1'b1; m_run[v] = 1; m_age[v] = 0; end
                    else      begin m_run[v] = 0; m_age[v] = 0; end
                end else if (m_run[v]) begin
                    m_age[v] = tk ? 0 : m_age[v] + 1;
                end
                m_stat[v] = (m_stat[v] & ~clrv) | setv;
            end
        end
        #2;
        if (rst_n && !done) begin
            compare(0, rd0, irq0);
            compare(1, rd1, irq1);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(logic sel, logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(logic [31:0] bits);
        @(negedge clk);
        src_set = bits;
        @(negedge clk);
        src_set = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired during %s", cur_req);
        finish_run();
    end

    initial begin
        // R6: reset state
        idle(3);
        rst_n = 1'b1;
        reg_sel = 1'b1; idle(3);
        reg_sel = 1'b0; idle(3);
        // R9 R10: enable readback, bit 0 clear keeps generator stopped
        cur_req = "R9";
        write(1'b0, 32'hA5A5_F0F0);
        idle(3);
        reg_sel = 1'b1; idle(2);
        // R7: source pulses
        cur_req = "R7";
        pulse(32'h8000_0F0E);
        pulse(32'h0008_0000);
        idle(2);
        // R2: clear everything through the variant mask
        cur_req = "R2";
        write(1'b1, 32'hFFFF_FFFF);
        idle(2);
        pulse(32'hFFFF_FFFE);
        write(1'b1, 32'h0F0F_0F0F);
        idle(2);
        // R1: irq from enabled status bits
        cur_req = "R1";
        write(1'b0, 32'h0000_0100);
        reg_sel = 1'b0; idle(2);
        write(1'b0, 32'h8000_0000);
        idle(2);
        write(1'b0, 32'h0000_0000);
        write(1'b1, 32'hFFFF_FFFF);
        // R3 R5: start generator, watch several frames, clearing bit 0
        cur_req = "R5";
        write(1'b0, 32'h0000_0001);
        for (int k = 0; k < 4; k++) begin
            idle(7);
            write(1'b1, 32'h0000_0001);
            reg_sel = 1'b1;
        end
        idle(FRAME * 2);
        // R3: restart partway through a period
        cur_req = "R3";
        write(1'b1, 32'h0000_0001);
        idle(9);
        write(1'b0, 32'h0000_0003);
        write(1'b1, 32'h0000_0001);
        reg_sel = 1'b1;
        idle(FRAME + 3);
        // R8: set and clear in the same cycle
        cur_req = "R8";
        @(negedge clk);
        src_set = 32'h0000_0004; reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h0000_0005;
        @(negedge clk);
        src_set = '0; reg_wr = 1'b0;
        idle(2);
        // R4: stop generator, nothing more arrives
        cur_req = "R4";
        write(1'b0, 32'h0000_0004);
        write(1'b1, 32'hFFFF_FFFF);
        reg_sel = 1'b1;
        idle(FRAME * 3);
        // R6: reset in the middle of a frame
        cur_req = "R6";
        write(1'b0, 32'hFFFF_FFFF);
        idle(5);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        reg_sel = 1'b1;
        idle(FRAME * 2);
        reg_sel = 1'b0; idle(2);
        finish_run();
    end
endmodule